// File: doc/BRIEF.md
# Periodic Down-Counting Reload Timer

This block is a single 16-bit timer channel reached over a plain word-wide register bus. Software places a start value in the reload register. The same write copies that value into the counter at once. Software then writes the control register with its enable bit set, and the counter begins to count down.

The counter moves only in cycles where the tick input is high. That input is a clock enable that the chip drives at a fixed 1 MHz rate. When the counter is at zero, the next tick brings it back to the reload value, so the count repeats with a period of reload + 1 ticks.

Setting the reset bit in a control write returns the whole block to its idle state. After the enable bit has started the counter, only a reset of either kind stops it.

Top module: `reload_timer`

## Requirements
- R1: After hardware reset, the control register at offset 0x00, the reload register at 0x04 and the count register at 0x08 all read zero, and ticks leave the count unchanged.
- R2: A control write whose bit 31 is clear stores all 32 written bits, and the control register then reads back that value.
- R3: A control write whose bit 31 is set performs a soft reset. The rest of the written value is discarded, the control, reload and count registers all read zero afterwards, and the counter is stopped.
- R4: A control write with bit 0 set and bit 31 clear starts the counter. While it runs, each tick lowers a nonzero count by exactly one.
- R5: Once the counter is running, a control write with bit 0 clear (and bit 31 clear) does not stop it.
- R6: A reload write keeps only bits 15:0 and reads back with bits 31:16 as zero. The counter takes that value in the cycle after the write, whether or not it is running.
- R7: While running, a tick that finds the count at zero loads the reload value, so the count repeats every reload + 1 ticks.
- R8: While running with a reload value of zero, the count stays at zero on every tick.
- R9: A write to the count register (offset 0x08) has no effect on the count or on any other register.
- R10: Every offset other than 0x00, 0x04 and 0x08 in the 256-byte window reads zero, and writes to it change nothing. This includes offsets that are not word aligned.
- R11: In cycles with the tick input low, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Single-cycle pulse at the 1 MHz count rate |
| busAddr | input | 8 | Byte offset in the register window |
| busWe | input | 1 | Write strobe for one cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |

## Verification
The hardest situation to reach from the ports is the wrap from zero to the reload value, seen for every reload value and at every phase of the period. The bench sweeps each reload value from 0 to 7. For each value it runs more than two full periods and compares the count after every tick against N - (k mod (N+1)), where N is the reload value and k is the number of ticks since start.

Two further checks separate the enable-clear and count-write cases from a stopped counter. After each such write, a few more ticks must still move the count.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef struct packed {
    logic softRst;
    logic startRun;
    logic loadReload;
  } ctlStrobes_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int RST_BIT = 31,
  parameter int EN_BIT = 0,
  parameter logic [ADDR_W-1:0] CTL_OFS = 8'h00,
  parameter logic [ADDR_W-1:0] RLD_OFS = 8'h04
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output ctlStrobes_t       strobes,
  output logic [DATA_W-1:0] ctlReg
);
  logic ctlWrite;

  assign ctlWrite = busWe && (busAddr == CTL_OFS);

  always_comb begin
    strobes.softRst    = ctlWrite && busWdata[RST_BIT];
    strobes.startRun   = ctlWrite && !busWdata[RST_BIT] && busWdata[EN_BIT];
    strobes.loadReload = busWe && (busAddr == RLD_OFS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                ctlReg <= '0;
    else if (strobes.softRst) ctlReg <= '0;
    else if (ctlWrite)        ctlReg <= busWdata;
  end

  // R3
  soft_rst_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == CTL_OFS && busWdata[RST_BIT]) |=> (ctlReg == '0));

  // R2
  ctl_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == CTL_OFS && !busWdata[RST_BIT]) |=> (ctlReg == $past(busWdata)));
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] busWdata,
  output logic [CNT_W-1:0]  reloadReg,
  output logic [CNT_W-1:0]  countReg,
  output logic              running
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadReg <= '0;
      countReg  <= '0;
      running   <= 1'b0;
    end else if (strobes.softRst) begin
      reloadReg <= '0;
      countReg  <= '0;
      running   <= 1'b0;
    end else begin
      if (strobes.startRun) running <= 1'b1;
      if (strobes.loadReload) begin
        reloadReg <= busWdata[CNT_W-1:0];
        countReg  <= busWdata[CNT_W-1:0];
      end else if (running && tickEn) begin
        if (countReg == '0) countReg <= reloadReg;
        else                countReg <= countReg - 1'b1;
      end
    end
  end

  // R6
  load_now_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadReload && !strobes.softRst) |=> (countReg == $past(busWdata[CNT_W-1:0])));

  // R4
  dec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && tickEn && countReg != '0 && strobes == '0) |=> (countReg == $past(countReg) - 1'b1));

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && tickEn && countReg == '0 && strobes == '0) |=> (countReg == $past(reloadReg)));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && strobes == '0) |=> $stable(countReg));

  // R5
  stay_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && !strobes.softRst) |=> running);
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata
);
  localparam logic [ADDR_W-1:0] CTL_OFS = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] RLD_OFS = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] CNT_OFS = ADDR_W'(8'h08);
  localparam int PAD_W = DATA_W - CNT_W;

  ctlStrobes_t       strobes;
  logic [DATA_W-1:0] ctlReg;
  logic [CNT_W-1:0]  reloadReg;
  logic [CNT_W-1:0]  countReg;
  logic              running;

  timer_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_BIT(DATA_W-1), .EN_BIT(0),
    .CTL_OFS(CTL_OFS), .RLD_OFS(RLD_OFS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .strobes(strobes), .ctlReg(ctlReg)
  );

  timer_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strobes(strobes),
    .busWdata(busWdata), .reloadReg(reloadReg), .countReg(countReg),
    .running(running)
  );

  always_comb begin
    unique case (busAddr)
      CTL_OFS: busRdata = ctlReg;
      RLD_OFS: busRdata = {{PAD_W{1'b0}}, reloadReg};
      CNT_OFS: busRdata = {{PAD_W{1'b0}}, countReg};
      default: busRdata = '0;
    endcase
  end

  // R9
  cnt_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == CNT_OFS && !tickEn) |=> ($stable(countReg) && $stable(reloadReg) && $stable(ctlReg)));

  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != CTL_OFS && busAddr != RLD_OFS && busAddr != CNT_OFS) |-> (busRdata == '0));
endmodule

// File: tb/tb_reload_timer.sv
module tb_reload_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  reload_timer dut (.*);

  always #5 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic tick();
    @(negedge clk); tickEn = 1'b1;
    @(negedge clk); tickEn = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] c0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rd(8'h00, v); check("R1 ctl", v, 0);
    rd(8'h04, v); check("R1 reload", v, 0);
    rd(8'h08, v); check("R1 count", v, 0);
    wr(8'h04, 32'h0000_0003);
    tick(); tick();
    rd(8'h08, v); check("R1 idle count", v, 3);

    wr(8'h00, 32'h7654_3210);
    rd(8'h00, v); check("R2 ctl store", v, 32'h7654_3210);

    wr(8'h04, 32'hABCD_1234);
    rd(8'h04, v); check("R6 reload mask", v, 32'h0000_1234);
    rd(8'h08, v); check("R6 count load", v, 32'h0000_1234);

    // R11: no ticks, idle cycles
    wr(8'h00, 32'h0000_0001);
    repeat (5) @(negedge clk);
    rd(8'h08, v); check("R11 hold", v, 32'h1234);
    tick();
    rd(8'h08, v); check("R4 dec", v, 32'h1233);

    // R5
    wr(8'h00, 32'h0000_0000);
    rd(8'h00, v); check("R5 ctl readback", v, 0);
    tick();
    rd(8'h08, v); check("R5 still runs", v, 32'h1232);

    // R9
    wr(8'h08, 32'h0000_0077);
    rd(8'h08, v); check("R9 count unchanged", v, 32'h1232);
    rd(8'h04, v); check("R9 reload unchanged", v, 32'h1234);
    tick();
    rd(8'h08, v); check("R9 still runs", v, 32'h1231);

    // R6 load while running
    wr(8'h04, 32'h0000_0009);
    rd(8'h08, v); check("R6 load running", v, 9);

    // R3
    wr(8'h00, 32'h8000_00FF);
    rd(8'h00, v); check("R3 ctl zero", v, 0);
    rd(8'h04, v); check("R3 reload zero", v, 0);
    rd(8'h08, v); check("R3 count zero", v, 0);
    wr(8'h04, 32'h0000_0005);
    tick(); tick();
    rd(8'h08, v); check("R3 stopped", v, 5);

    // R7 / R8 sweep
    for (int n = 0; n < 8; n++) begin
      wr(8'h00, 32'h8000_0000);
      wr(8'h04, 32'(n));
      wr(8'h00, 32'h0000_0001);
      for (int k = 1; k <= 2 * (n + 1) + 2; k++) begin
        tick();
        rd(8'h08, v);
        if (n == 0) check("R8 zero reload", v, 0);
        else check("R7 wrap sweep", v, 32'(n - (k % (n + 1))));
      end
    end

    // R10
    wr(8'h00, 32'h8000_0000);
    wr(8'h00, 32'h1234_5670);
    wr(8'h04, 32'h0000_0055);
    for (int a = 0; a < 256; a++) begin
      if (a != 0 && a != 4 && a != 8) begin
        rd(8'(a), v); check("R10 unmapped read", v, 0);
        wr(8'(a), 32'hFFFF_FFFF);
      end
    end
    rd(8'h00, v); check("R10 ctl intact", v, 32'h1234_5670);
    rd(8'h04, v); check("R10 reload intact", v, 32'h55);
    tick();
    rd(8'h08, v); check("R10 count intact", v, 32'h55);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule